// File: doc/BRIEF.md
# Request/Grant DMA Handshake Sequencer

This block serves one DMA channel at the edge of a chip. An external device asks for a transfer by pulling an active-low request line. The block replies with one data transfer, timed by an active-low grant strobe. Each falling edge of the request, seen after synchronization, starts one transfer. The grant stays low for a programmable number of wait states. The device can lengthen the access one cycle at a time by keeping the request low. An optional extra cycle after the grant keeps the select asserted and delays the start of the next transfer.

Three modes share the same sequencer:
- **Plain handshake:** only the grant is driven. The grant latches inbound data and enables outbound data.
- **External handshake:** the read or write strobe and the select are also driven around the grant.
- **Paced master:** no grant is issued. The access runs as an ordinary strobed bus cycle, paced by the request.

Mode, direction, wait count and hold enable are captured when a transfer starts. A one-clock done pulse marks the end of every transfer.

Top module: `dma_hs_ctrl`

## Requirements
- R1: The request passes through a two-stage synchronizer. If clock edge k is the first edge at which the request is low, the access phase begins at edge k+3. In the modes that use a grant, the grant goes low at that edge.
- R2: Mode codes are as follows: 0 is plain handshake, 1 is external handshake, 2 is paced master, and 3 behaves as plain handshake. In paced-master mode the grant never goes low.
- R3: A transfer starts only on a new high-to-low change of the synchronized request. A request held low does not start a second transfer. A falling edge that arrives while a transfer is in progress is remembered and served once that transfer has finished.
- R4: With wait count W (0 to 7) and no stretch, the access phase lasts W+1 clock cycles. In grant modes the grant is low for exactly these cycles.
- R5: A request held low for L cycles keeps the access phase going while its synchronized copy is still low. The access therefore lasts max(W+1, L-1) cycles.
- R6: In external handshake mode:
  - The read strobe (inbound, dir 0) or write strobe (outbound, dir 1) goes low one cycle before the grant falls.
  - That strobe rises on the same edge as the grant.
  - The select is low from the strobe's fall until one cycle after the grant rises.
  - In total the strobe is low for access+1 cycles.
- R7: In the external handshake and paced-master modes, setting the hold enable keeps the select low for one further cycle, giving access+3 cycles in all. Without the hold enable the select is low for access+2 cycles.
- R8: For outbound transfers (dir 1), data captured from the transmit input at the start is driven with its output enable high. This happens only during the access cycles. Inbound transfers never raise the enable.
- R9: For inbound transfers (dir 0), the external data bus is captured on the edge that ends the access phase, which in grant modes is the edge where the grant rises. An outbound transfer leaves the received-data output unchanged.
- R10: Mode, direction, wait count and hold enable are sampled only when a transfer starts. Changing them during a transfer has no effect on it.
- R11: Each transfer raises the done output for exactly one clock cycle, in the cycle after the access phase ends.
- R12: During reset the strobes are all high, the output enable and done are low, and the received data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dmar_n_i | input | 1 | Asynchronous active-low transfer request |
| mode_i | input | 2 | Handshake mode code |
| dir_i | input | 1 | 1 = outbound (block drives data), 0 = inbound |
| wait_i | input | 3 | Wait-state count W |
| hold_en_i | input | 1 | Adds the hold/idle cycle after the grant |
| tx_data_i | input | DATA_W | Outbound data, captured at transfer start |
| ext_data_i | input | DATA_W | External data bus as seen by the block |
| grant_n_o | output | 1 | Active-low grant strobe |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| sel_n_o | output | 1 | Active-low address/select valid |
| ext_data_o | output | DATA_W | Outbound data value |
| ext_data_oe_o | output | 1 | Tri-state enable for ext_data_o |
| rx_data_o | output | DATA_W | Last inbound data captured |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
The hardest situation to reach from the ports is a second request edge that falls while a transfer is still running. The remembered start must then follow the previous transfer, including its optional hold cycle, with no loss and no duplicate. The stimulus uses the longest wait count and pulses the request a second time in the middle of the grant. It then checks that two scoreboard items, each with its own strobe widths, are produced in order. Stretched accesses are reached by holding the request low for longer than the wait count, and the expected width follows the synchronizer delay given in R5.

// File: rtl/dma_hs_pkg.sv
// Shared definitions for the DMA request/grant handshake sequencer.
// Assumes: mode codes are fixed by the software-visible encoding of R2.
package dma_hs_pkg;

    localparam logic [1:0] MODE_PLAIN = 2'd0;
    localparam logic [1:0] MODE_EXT   = 2'd1;
    localparam logic [1:0] MODE_PACED = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_ACCESS = 3'd2,
        ST_END    = 3'd3,
        ST_HOLD   = 3'd4
    } seq_state_t;

endpackage

// File: rtl/dma_req_sync.sv
// Request synchronizer and falling-edge detector.
// Brings the asynchronous active-low request into the clock domain through
// STAGES flops, then flags one cycle when the synchronized copy goes low.
// Assumes: STAGES >= 2; the request must stay low for at least one clock to
// be guaranteed to be seen.
module dma_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n_i,
    output logic req_low_o,
    output logic req_fall_o
);

    logic [STAGES-1:0] chain_q;
    logic              low_prev_q;

    // Shift the raw request through the synchronizer chain.
    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= 1'b1;
                    else        chain_q[0] <= req_n_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= 1'b1;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign req_low_o = ~chain_q[STAGES-1];

    // Remember last cycle's synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) low_prev_q <= 1'b0;
        else        low_prev_q <= req_low_o;
    end

    assign req_fall_o = req_low_o & ~low_prev_q;

endmodule

// File: rtl/dma_grant_seq.sv
// Transfer sequencer: IDLE -> SETUP -> ACCESS (W+1 cycles, stretched while
// the request stays low) -> END -> optional HOLD -> IDLE.
// A request edge seen while busy is kept pending and served afterwards.
// Assumes: wait count and hold enable are stable in the start cycle.
module dma_grant_seq
    import dma_hs_pkg::*;
#(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_low_i,
    input  logic              req_fall_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              hold_en_i,
    output seq_state_t        state_o,
    output logic              start_o,
    output logic              exit_o
);

    seq_state_t        state_q;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W-1:0] cnt_q;
    logic              hold_q;
    logic              pend_q;
    logic              cnt_zero;

    assign cnt_zero = (cnt_q == '0);
    assign start_o  = (state_q == ST_IDLE) && (req_fall_i || pend_q);
    assign exit_o   = (state_q == ST_ACCESS) && cnt_zero && !req_low_i;
    assign state_o  = state_q;

    // Keep a request edge that arrives while a transfer is running.
    always_ff @(posedge clk) begin
        if (!rst_n)                                pend_q <= 1'b0;
        else if (req_fall_i && state_q != ST_IDLE) pend_q <= 1'b1;
        else if (start_o)                          pend_q <= 1'b0;
    end

    // Capture timing configuration at transfer start only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            hold_q <= 1'b0;
        end else if (start_o) begin
            wait_q <= wait_i;
            hold_q <= hold_en_i;
        end
    end

    // Advance the transfer state and the wait-state counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_o) state_q <= ST_SETUP;
                end
                ST_SETUP: begin
                    state_q <= ST_ACCESS;
                    cnt_q   <= wait_q;
                end
                ST_ACCESS: begin
                    if (!cnt_zero)       cnt_q   <= cnt_q - 1'b1;
                    else if (!req_low_i) state_q <= ST_END;
                end
                ST_END: begin
                    state_q <= hold_q ? ST_HOLD : ST_IDLE;
                end
                ST_HOLD: begin
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dma_strobe_dec.sv
// Strobe decoder and data path.
// Turns the sequencer state and the mode/direction captured at start into
// grant, read/write, select, tri-state enable and done; holds outbound data
// and captures inbound data at the end of the access.
// Assumes: the state only leaves IDLE through a start cycle.
module dma_strobe_dec
    import dma_hs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_t        state_i,
    input  logic              start_i,
    input  logic              exit_i,
    input  logic [1:0]        mode_i,
    input  logic              dir_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic [DATA_W-1:0] ext_data_i,
    output logic [1:0]        mode_o,
    output logic              grant_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              sel_n_o,
    output logic [DATA_W-1:0] ext_data_o,
    output logic              ext_data_oe_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              done_o
);

    logic [1:0]        mode_q;
    logic              dir_q;
    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic              bus_mode;
    logic              paced;
    logic              in_access;
    logic              strobe_on;
    logic              sel_on;

    // Capture mode, direction and outbound data at transfer start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_PLAIN;
            dir_q  <= 1'b0;
            tx_q   <= '0;
        end else if (start_i) begin
            mode_q <= mode_i;
            dir_q  <= dir_i;
            tx_q   <= tx_data_i;
        end
    end

    // Latch inbound data on the edge that closes the access.
    always_ff @(posedge clk) begin
        if (!rst_n)                rx_q <= '0;
        else if (exit_i && !dir_q) rx_q <= ext_data_i;
    end

    // Decode the strobes from the registered state.
    always_comb begin
        paced     = (mode_q == MODE_PACED);
        bus_mode  = paced || (mode_q == MODE_EXT);
        in_access = (state_i == ST_ACCESS);
        strobe_on = bus_mode && (state_i == ST_SETUP || in_access);
        sel_on    = bus_mode && (state_i == ST_SETUP || in_access ||
                                 state_i == ST_END   || state_i == ST_HOLD);
    end

    assign mode_o        = mode_q;
    assign grant_n_o     = !(in_access && !paced);
    assign rd_n_o        = !(strobe_on && !dir_q);
    assign wr_n_o        = !(strobe_on && dir_q);
    assign sel_n_o       = !sel_on;
    assign ext_data_o    = tx_q;
    assign ext_data_oe_o = in_access && dir_q;
    assign rx_data_o     = rx_q;
    assign done_o        = (state_i == ST_END);

endmodule

// File: rtl/dma_hs_ctrl.sv
// Top of the per-channel DMA request/grant handshake controller.
// Chains the request synchronizer, the transfer sequencer and the strobe
// decoder. Assumes one clock domain; only dmar_n_i is asynchronous.
module dma_hs_ctrl
    import dma_hs_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int WAIT_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dmar_n_i,
    input  logic [1:0]        mode_i,
    input  logic              dir_i,
    input  logic [WAIT_W-1:0] wait_i,
    input  logic              hold_en_i,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic [DATA_W-1:0] ext_data_i,
    output logic              grant_n_o,
    output logic              rd_n_o,
    output logic              wr_n_o,
    output logic              sel_n_o,
    output logic [DATA_W-1:0] ext_data_o,
    output logic              ext_data_oe_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              done_o
);

    logic       req_low;
    logic       req_fall;
    logic       start;
    logic       exit_acc;
    logic [1:0] cfg_mode;
    seq_state_t state;

    dma_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_n_i    (dmar_n_i),
        .req_low_o  (req_low),
        .req_fall_o (req_fall)
    );

    dma_grant_seq #(.WAIT_W(WAIT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_low_i  (req_low),
        .req_fall_i (req_fall),
        .wait_i     (wait_i),
        .hold_en_i  (hold_en_i),
        .state_o    (state),
        .start_o    (start),
        .exit_o     (exit_acc)
    );

    dma_strobe_dec #(.DATA_W(DATA_W)) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .state_i       (state),
        .start_i       (start),
        .exit_i        (exit_acc),
        .mode_i        (mode_i),
        .dir_i         (dir_i),
        .tx_data_i     (tx_data_i),
        .ext_data_i    (ext_data_i),
        .mode_o        (cfg_mode),
        .grant_n_o     (grant_n_o),
        .rd_n_o        (rd_n_o),
        .wr_n_o        (wr_n_o),
        .sel_n_o       (sel_n_o),
        .ext_data_o    (ext_data_o),
        .ext_data_oe_o (ext_data_oe_o),
        .rx_data_o     (rx_data_o),
        .done_o        (done_o)
    );

endmodule

// File: rtl/dma_hs_ctrl_chk.sv
// Protocol checker for dma_hs_ctrl, attached by bind. Relates the strobes,
// the done pulse and the captured data over time.
module dma_hs_ctrl_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grant_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              sel_n,
    input logic              oe,
    input logic              done,
    input logic [1:0]        mode_q,
    input logic [DATA_W-1:0] rx
);

    // R2: paced-master transfers never drop the grant.
    p_paced_no_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd2) |-> grant_n);

    // R4: the grant rises exactly when the transfer reports done.
    p_grant_rise_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grant_n) |-> done);

    // R6: a strobe is already low in the cycle before the grant falls.
    p_strobe_leads_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && $fell(grant_n)) |-> $past(!rd_n || !wr_n));

    // R6: strobes are released with the grant, and select is still held.
    p_strobe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1 && $rose(grant_n)) |-> (rd_n && wr_n && !sel_n));

    // R8: outbound data is enabled only while the grant is low.
    p_oe_in_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && mode_q != 2'd2) |-> !grant_n);

    // R9: received data changes only as a transfer completes.
    p_rx_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx) |-> done);

    // R11: the done pulse lasts a single cycle.
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind dma_hs_ctrl dma_hs_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .grant_n (grant_n_o),
    .rd_n    (rd_n_o),
    .wr_n    (wr_n_o),
    .sel_n   (sel_n_o),
    .oe      (ext_data_oe_o),
    .done    (done_o),
    .mode_q  (cfg_mode),
    .rx      (rx_data_o)
);

// File: tb/dma_hs_ctrl_test.sv
// Scoreboard bench: the driver pushes one expected record per transfer, and
// the monitor measures each transfer at the ports and compares.
module dma_hs_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;

    typedef struct {
        int          grant;
        int          rd;
        int          wr;
        int          sel;
        int          oe;
        logic [15:0] oe_val;
        logic [15:0] rx;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dmar_n = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic          dir = 1'b0;
    logic [2:0]    wait_cnt = 3'd0;
    logic          hold_en = 1'b0;
    logic [DW-1:0] tx_data = '0;
    logic [DW-1:0] ext_data = '0;
    logic          grant_n, rd_n, wr_n, sel_n, oe, done;
    logic [DW-1:0] ext_out, rx_data;

    int   n_vec = 0;
    int   n_bad = 0;
    int   n_pushed = 0;
    int   n_seen = 0;
    logic [15:0] rx_model = '0;
    exp_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_hs_ctrl #(.DATA_W(DW), .WAIT_W(3), .SYNC_STAGES(2)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .dmar_n_i      (dmar_n),
        .mode_i        (mode),
        .dir_i         (dir),
        .wait_i        (wait_cnt),
        .hold_en_i     (hold_en),
        .tx_data_i     (tx_data),
        .ext_data_i    (ext_data),
        .grant_n_o     (grant_n),
        .rd_n_o        (rd_n),
        .wr_n_o        (wr_n),
        .sel_n_o       (sel_n),
        .ext_data_o    (ext_out),
        .ext_data_oe_o (oe),
        .rx_data_o     (rx_data),
        .done_o        (done)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Build the expected record from the requirements.
    task automatic push_exp(input logic [1:0] m, input int w, input bit h,
                            input bit d, input int l, input string tag);
        exp_t e;
        int   acc;
        bit   paced, bus;
        acc   = (w + 1 > l - 1) ? w + 1 : l - 1;          // R4, R5
        paced = (m == 2'd2);
        bus   = paced || (m == 2'd1);
        e.grant  = paced ? 0 : acc;                       // R2
        e.rd     = (bus && !d) ? acc + 1 : 0;             // R6
        e.wr     = (bus && d) ? acc + 1 : 0;
        e.sel    = bus ? acc + 2 + (h ? 1 : 0) : 0;       // R7
        e.oe     = d ? acc : 0;                           // R8
        e.oe_val = tx_data;
        if (!d) rx_model = ext_data;                      // R9
        e.rx     = rx_model;
        e.tag    = tag;
        sb_q.push_back(e);
        n_pushed++;
    endtask

    task automatic pulse_req(input int l);
        @(negedge clk) dmar_n = 1'b0;
        repeat (l) @(negedge clk);
        dmar_n = 1'b1;
    endtask

    task automatic settle();
        wait (sb_q.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // One full transfer; scramble changes the configuration mid-transfer (R10).
    task automatic xfer(input logic [1:0] m, input int w, input bit h, input bit d,
                        input int l, input logic [15:0] tx, input logic [15:0] inb,
                        input bit scramble, input string tag);
        @(negedge clk);
        mode = m; wait_cnt = 3'(w); hold_en = h; dir = d;
        tx_data = tx; ext_data = inb;
        push_exp(m, w, h, d, l, tag);
        pulse_req(l);
        if (scramble) begin
            repeat (2) @(negedge clk);
            mode = ~m; wait_cnt = ~3'(w); hold_en = ~h; dir = ~d;
            tx_data = ~tx;
        end
        settle();
    endtask

    // Monitor: measure each transfer at the ports and compare with the queue.
    int  c_grant = 0, c_rd = 0, c_wr = 0, c_sel = 0, c_oe = 0, c_done = 0;
    bit  oe_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (!grant_n) c_grant++;
            if (!rd_n)    c_rd++;
            if (!wr_n)    c_wr++;
            if (!sel_n)   c_sel++;
            if (oe) begin
                c_oe++;
                if (sb_q.size() > 0 && ext_out != sb_q[0].oe_val) oe_bad = 1;
            end
            if (done) c_done++;
            if (c_done > 0 && sel_n && grant_n && rd_n && wr_n) begin
                n_seen++;
                if (sb_q.size() == 0) begin
                    chk(0, "R3 unexpected transfer", n_seen, n_pushed);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    chk(c_grant == e.grant, {"R4/R5 grant width ", e.tag}, c_grant, e.grant);
                    chk(c_rd == e.rd,       {"R6 read strobe ", e.tag},    c_rd, e.rd);
                    chk(c_wr == e.wr,       {"R6 write strobe ", e.tag},   c_wr, e.wr);
                    chk(c_sel == e.sel,     {"R7 select width ", e.tag},   c_sel, e.sel);
                    chk(c_oe == e.oe && !oe_bad, {"R8 data enable ", e.tag}, c_oe, e.oe);
                    chk(rx_data == e.rx,    {"R9 rx data ", e.tag},        int'(rx_data), int'(e.rx));
                    chk(c_done == 1,        {"R11 done pulses ", e.tag},   c_done, 1);
                end
                c_grant = 0; c_rd = 0; c_wr = 0; c_sel = 0; c_oe = 0; c_done = 0;
                oe_bad = 0;
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R12: reset state
        repeat (4) @(negedge clk);
        chk(grant_n && rd_n && wr_n && sel_n, "R12 strobes high in reset", 0, 1);
        chk(!oe && !done, "R12 enable/done low in reset", int'(oe), 0);
        chk(rx_data == '0, "R12 rx zero in reset", int'(rx_data), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: grant falls at the fourth falling clock after the request drops
        mode = 2'd0; wait_cnt = 3'd0; dir = 1'b0; hold_en = 1'b0;
        ext_data = 16'h1111;
        push_exp(2'd0, 0, 0, 0, 1, "R1 latency");
        dmar_n = 1'b0;
        @(negedge clk) dmar_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(grant_n == 1'b1, "R1 grant still high at third", int'(grant_n), 1);
        @(negedge clk);
        chk(grant_n == 1'b0, "R1 grant low at fourth", int'(grant_n), 0);
        settle();

        xfer(2'd0, 3, 0, 1, 1, 16'hA5A5, 16'h0000, 0, "R4 plain out W3");
        xfer(2'd1, 2, 0, 0, 1, 16'h0000, 16'h2222, 0, "R6 ext in W2");
        xfer(2'd1, 5, 1, 1, 1, 16'h5A5A, 16'h0000, 0, "R7 ext out hold");
        xfer(2'd1, 1, 1, 0, 2, 16'h0000, 16'h3333, 0, "R7 ext in hold");
        xfer(2'd2, 1, 0, 0, 1, 16'h0000, 16'h4444, 0, "R2 paced in");
        xfer(2'd2, 4, 1, 1, 1, 16'hC3C3, 16'h0000, 0, "R2 paced out hold");
        xfer(2'd1, 0, 0, 0, 8, 16'h0000, 16'h5555, 0, "R5 ext stretch");
        xfer(2'd0, 2, 0, 1, 10, 16'h0F0F, 16'h0000, 0, "R5 plain stretch");
        xfer(2'd0, 7, 0, 0, 20, 16'h0000, 16'h6666, 0, "R3 R5 long hold");
        xfer(2'd3, 1, 0, 0, 1, 16'h0000, 16'h7777, 0, "R2 code3 plain");
        xfer(2'd1, 2, 0, 0, 1, 16'h0000, 16'h8888, 1, "R10 scramble in");
        xfer(2'd0, 7, 0, 1, 1, 16'hBEEF, 16'h0000, 0, "R4 max wait");

        // R3: second edge during a running transfer is served afterwards
        @(negedge clk);
        mode = 2'd1; wait_cnt = 3'd7; hold_en = 1'b1; dir = 1'b1; tx_data = 16'h1234;
        push_exp(2'd1, 7, 1, 1, 1, "R3 first of pair");
        push_exp(2'd1, 7, 1, 1, 1, "R3 pending second");
        pulse_req(1);
        repeat (4) @(negedge clk);
        pulse_req(1);
        settle();

        // R3: no extra transfer appears afterwards
        repeat (20) @(negedge clk);
        chk(n_seen == n_pushed, "R3 transfer count", n_seen, n_pushed);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule